// File: doc/BRIEF.md
# Handle-Stamped Event Log Queue

This block keeps several independent event logs, each a short queue of fixed-size records. A producer inserts an event into a chosen log. The block tags each accepted record with a fresh non-zero handle and with the value of a free-running time input. A consumer then reads records from the oldest end without removing them. To retire records, it sends a clear request that lists the handles it expects to find at the head of the log.

Each log has its own storage, handle counter and overflow statistics. When an insert finds its log full, the event is dropped. The drop is counted, and the time of the first drop and of the latest drop are kept until a record is removed. A per-log status bit shows that the log holds records. A one-cycle interrupt bit pulses when a log goes from empty to non-empty.

Operations arrive through a valid/ready port, one at a time. A read streams its records one per cycle and then returns a single response beat. A clear takes its handles one per cycle. It is checked as a whole before anything is removed.

Top module: `evlog_queue`

## Requirements
- R1: Each log holds at most DEPTH (8) records. An insert into a full log stores nothing and leaves the stored records unchanged.
- R2: Each log's handle counter is 1 after reset. It advances by one on every accepted insert, and after its all-ones value it goes to 1, so handle 0 is never issued. Dropped inserts do not advance it.
- R3: A stored record's timestamp is the value of `now` on the clock edge where the insert is accepted.
- R4: A dropped insert adds one to the log's overflow count, which saturates at all-ones. The drop also sets the last-overflow time to `now`. The first-overflow time is written only when the count was zero before the drop.
- R5: An accepted insert sets the log's `log_status` bit. The next cycle, `irq` pulses for one cycle on that log's bit only if the log was empty before the insert.
- R6: A read (op_code 1) with limit `op_num` streams min(op_num, occupancy) records, oldest first, on `rec_*`. It does not remove them. It then gives one `rsp_valid` beat with `rsp_count` equal to the number streamed.
- R7: In a read response, `rsp_flags` bit 1 is set when the log is non-empty and bit 0 when its overflow count is non-zero. When bit 0 is set, the count and both overflow times are reported; otherwise those fields are zero.
- R8: A clear (op_code 2) takes `op_num` handles, one per `hnd_valid`/`hnd_ready` transfer. Handle i is compared with the i-th record from the head, and handles beyond the occupancy are not checked. If any checked handle is 0 or differs, `rsp_code` is 1 (invalid input) and nothing is removed. Otherwise `rsp_code` is 0, min(op_num, occupancy) head records are removed, and `rsp_count` reports that number.
- R9: Removing at least one record resets the overflow count and both overflow times to zero. A clear that empties a log drops its `log_status` bit.
- R10: A log type at or above NUM_LOGS is handled as follows. An insert is ignored, with no status change and no irq. A read responds with `rsp_code` 1 and no records. A clear still takes its handles and then responds with `rsp_code` 1.
- R11: Logs are independent. An operation on one log changes no other log's records, handles, overflow data or status.
- R12: `op_ready` is high only while no operation is in progress. Each accepted operation (op_code 0 insert, 1 read, 2 clear; 3 does nothing) is carried out once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now | input | TS_W | Free-running time value |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Block idle, request accepted this cycle |
| op_code | input | 2 | 0 insert, 1 read, 2 clear, 3 no-op |
| op_log | input | LOG_W | Log type selector |
| op_num | input | NUM_W | Read limit or clear handle count |
| op_payload | input | PAYLOAD_W | Opaque event word for insert |
| hnd_valid | input | 1 | Clear handle valid |
| hnd_ready | output | 1 | Block expects another clear handle |
| hnd_data | input | HANDLE_W | Clear handle |
| rec_valid | output | 1 | Read record beat |
| rec_handle | output | HANDLE_W | Record handle |
| rec_ts | output | TS_W | Record timestamp |
| rec_payload | output | PAYLOAD_W | Record payload word |
| rsp_valid | output | 1 | Response beat for read or clear |
| rsp_code | output | 2 | 0 success, 1 invalid input |
| rsp_flags | output | 2 | Bit 1 more records, bit 0 overflow |
| rsp_count | output | NUM_W | Records returned or removed |
| rsp_ovf_count | output | OVF_W | Overflow count |
| rsp_ovf_first | output | TS_W | First overflow time |
| rsp_ovf_last | output | TS_W | Last overflow time |
| log_status | output | NUM_LOGS | Per-log non-empty status |
| irq | output | NUM_LOGS | One-cycle empty-to-non-empty pulse per log |

## Verification
The checks assume the consumer drives `hnd_valid` only while a clear is in progress. They also assume it never asks for more than DEPTH records or handles, so `op_num` fits its width. The stimulus issues each operation only when `op_ready` is high and holds `op_valid` for exactly that one cycle. It streams exactly `op_num` handles back to back during a clear and keeps `hnd_valid` low at all other times. Handle lists are built from the bench's own model of each queue, with deliberate zero and wrong values placed in chosen positions.

// File: rtl/evlog_queue.sv
`timescale 1ns/1ps
module evlog_queue #(
  parameter int NUM_LOGS  = 4,
  parameter int LOG_W     = 3,
  parameter int DEPTH     = 8,
  parameter int NUM_W     = 4,
  parameter int PAYLOAD_W = 32,
  parameter int TS_W      = 32,
  parameter int HANDLE_W  = 16,
  parameter int OVF_W     = 16
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      now,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [1:0]           op_code,
  input  logic [LOG_W-1:0]     op_log,
  input  logic [NUM_W-1:0]     op_num,
  input  logic [PAYLOAD_W-1:0] op_payload,
  input  logic                 hnd_valid,
  output logic                 hnd_ready,
  input  logic [HANDLE_W-1:0]  hnd_data,
  output logic                 rec_valid,
  output logic [HANDLE_W-1:0]  rec_handle,
  output logic [TS_W-1:0]      rec_ts,
  output logic [PAYLOAD_W-1:0] rec_payload,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_code,
  output logic [1:0]           rsp_flags,
  output logic [NUM_W-1:0]     rsp_count,
  output logic [OVF_W-1:0]     rsp_ovf_count,
  output logic [TS_W-1:0]      rsp_ovf_first,
  output logic [TS_W-1:0]      rsp_ovf_last,
  output logic [NUM_LOGS-1:0]  log_status,
  output logic [NUM_LOGS-1:0]  irq
);
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LI_W  = (NUM_LOGS > 1) ? $clog2(NUM_LOGS) : 1;
  localparam int SLOTS = NUM_LOGS * DEPTH;
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [1:0] OP_INS = 2'd0, OP_RD = 2'd1, OP_CLR = 2'd2;
  localparam logic [1:0] RC_OK = 2'd0, RC_INVALID = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_CLR, S_RESP} state_t;
  state_t st;

  logic [PW-1:0]       head      [NUM_LOGS];
  logic [NUM_W-1:0]    occ       [NUM_LOGS];
  logic [HANDLE_W-1:0] nxt_h     [NUM_LOGS];
  logic [OVF_W-1:0]    ovc       [NUM_LOGS];
  logic [TS_W-1:0]     ovf_first [NUM_LOGS];
  logic [TS_W-1:0]     ovf_last  [NUM_LOGS];

  logic [HANDLE_W-1:0]  mem_h [SLOTS];
  logic [TS_W-1:0]      mem_t [SLOTS];
  logic [PAYLOAD_W-1:0] mem_p [SLOTS];

  logic [LI_W-1:0]  cur_log;
  logic             cur_bad, mism;
  logic [NUM_W-1:0] cur_num, idx;

  function automatic logic [SW-1:0] slot_of(input logic [LI_W-1:0] l, input logic [PW-1:0] p);
    return SW'(int'(l) * DEPTH + int'(p));
  endfunction

  logic [LI_W-1:0]     ol;
  logic                log_ok, is_full, ins_ok;
  logic [HANDLE_W-1:0] nh;
  logic [PW-1:0]       wr_ptr, rd_ptr;
  logic [SW-1:0]       wr_slot, cur_slot;
  logic [NUM_W-1:0]    occ_c, avail, take;
  logic                hit, chk_bad;

  assign op_ready = (st == S_IDLE);
  assign ol       = LI_W'(op_log);
  assign log_ok   = int'(op_log) < NUM_LOGS;
  assign is_full  = occ[ol] == NUM_W'(DEPTH);
  assign ins_ok   = op_valid && op_ready && op_code == OP_INS && log_ok && !is_full;
  assign nh       = (nxt_h[ol] == '1) ? HANDLE_W'(1) : nxt_h[ol] + HANDLE_W'(1);
  assign wr_ptr   = PW'((int'(head[ol]) + int'(occ[ol])) % DEPTH);
  assign wr_slot  = slot_of(ol, wr_ptr);

  assign occ_c    = occ[cur_log];
  assign avail    = cur_bad ? '0 : occ_c;
  assign take     = (cur_num < avail) ? cur_num : avail;
  assign rd_ptr   = PW'((int'(head[cur_log]) + int'(idx)) % DEPTH);
  assign cur_slot = slot_of(cur_log, rd_ptr);

  assign hnd_ready = (st == S_CLR) && (idx < cur_num);
  assign hit       = hnd_valid && hnd_ready;
  assign chk_bad   = (idx < avail) && (hnd_data == '0 || hnd_data != mem_h[cur_slot]);

  assign rec_valid   = (st == S_READ) && (idx < take);
  assign rec_handle  = mem_h[cur_slot];
  assign rec_ts      = mem_t[cur_slot];
  assign rec_payload = mem_p[cur_slot];
  assign rsp_valid   = (st == S_RESP);

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      mem_h[wr_slot] <= nxt_h[ol];
      mem_t[wr_slot] <= now;
      mem_p[wr_slot] <= op_payload;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cur_log       <= '0;
      cur_bad       <= 1'b0;
      cur_num       <= '0;
      idx           <= '0;
      mism          <= 1'b0;
      log_status    <= '0;
      irq           <= '0;
      rsp_code      <= RC_OK;
      rsp_flags     <= '0;
      rsp_count     <= '0;
      rsp_ovf_count <= '0;
      rsp_ovf_first <= '0;
      rsp_ovf_last  <= '0;
      for (int i = 0; i < NUM_LOGS; i++) begin
        head[i]      <= '0;
        occ[i]       <= '0;
        nxt_h[i]     <= HANDLE_W'(1);
        ovc[i]       <= '0;
        ovf_first[i] <= '0;
        ovf_last[i]  <= '0;
      end
    end else begin
      irq <= '0;
      unique case (st)
        S_IDLE: if (op_valid) begin
          cur_log <= ol;
          cur_bad <= !log_ok;
          cur_num <= op_num;
          idx     <= '0;
          mism    <= 1'b0;
          case (op_code)
            OP_INS: if (log_ok) begin
              if (is_full) begin
                if (ovc[ol] == '0) ovf_first[ol] <= now;
                if (ovc[ol] != '1) ovc[ol] <= ovc[ol] + OVF_W'(1);
                ovf_last[ol] <= now;
              end else begin
                occ[ol]        <= occ[ol] + NUM_W'(1);
                nxt_h[ol]      <= nh;
                log_status[ol] <= 1'b1;
                if (occ[ol] == '0) irq[ol] <= 1'b1;
              end
            end
            OP_RD:   st <= S_READ;
            OP_CLR:  st <= S_CLR;
            default: ;
          endcase
        end
        S_READ: begin
          if (idx < take) begin
            idx <= idx + NUM_W'(1);
          end else begin
            st <= S_RESP;
            if (cur_bad) begin
              rsp_code      <= RC_INVALID;
              rsp_flags     <= '0;
              rsp_count     <= '0;
              rsp_ovf_count <= '0;
              rsp_ovf_first <= '0;
              rsp_ovf_last  <= '0;
            end else begin
              rsp_code      <= RC_OK;
              rsp_flags     <= {occ_c != '0, ovc[cur_log] != '0};
              rsp_count     <= take;
              rsp_ovf_count <= ovc[cur_log];
              rsp_ovf_first <= (ovc[cur_log] != '0) ? ovf_first[cur_log] : '0;
              rsp_ovf_last  <= (ovc[cur_log] != '0) ? ovf_last[cur_log]  : '0;
            end
          end
        end
        S_CLR: begin
          if (hit) begin
            idx <= idx + NUM_W'(1);
            if (chk_bad) mism <= 1'b1;
          end else if (idx == cur_num) begin
            st            <= S_RESP;
            rsp_flags     <= '0;
            rsp_ovf_count <= '0;
            rsp_ovf_first <= '0;
            rsp_ovf_last  <= '0;
            if (cur_bad || mism) begin
              rsp_code  <= RC_INVALID;
              rsp_count <= '0;
            end else begin
              rsp_code      <= RC_OK;
              rsp_count     <= take;
              occ[cur_log]  <= occ_c - take;
              head[cur_log] <= PW'((int'(head[cur_log]) + int'(take)) % DEPTH);
              if (take != '0) begin
                ovc[cur_log]       <= '0;
                ovf_first[cur_log] <= '0;
                ovf_last[cur_log]  <= '0;
              end
              if (occ_c == take) log_status[cur_log] <= 1'b0;
            end
          end
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evlog_queue_chk.sv
`timescale 1ns/1ps
module evlog_queue_chk #(
  parameter int NUM_LOGS = 4,
  parameter int DEPTH    = 8,
  parameter int NUM_W    = 4,
  parameter int HANDLE_W = 16
)(
  input logic                clk,
  input logic                rst_n,
  input logic                op_ready,
  input logic                rec_valid,
  input logic [HANDLE_W-1:0] rec_handle,
  input logic                hnd_ready,
  input logic                rsp_valid,
  input logic [1:0]          rsp_code,
  input logic [1:0]          rsp_flags,
  input logic [NUM_W-1:0]    rsp_count,
  input logic [NUM_LOGS-1:0] log_status,
  input logic [NUM_LOGS-1:0] irq
);
  a_r2_handle_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_handle != '0);

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  a_r5_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~log_status) == '0);

  a_r9_status_fall_at_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(log_status) & ~log_status) != '0) |-> rsp_valid);

  a_r10_invalid_empty_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> (rsp_count == '0 && rsp_flags == 2'd0));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> int'(rsp_count) <= DEPTH);

  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid || hnd_ready || rsp_valid) |-> !op_ready);
endmodule

bind evlog_queue evlog_queue_chk #(
  .NUM_LOGS(NUM_LOGS), .DEPTH(DEPTH), .NUM_W(NUM_W), .HANDLE_W(HANDLE_W)
) chk_i (.*);

// File: tb/evlog_queue_tb_top.sv
`timescale 1ns/1ps
module evlog_queue_tb_top;
  localparam int NL = 4, LW = 3, D = 8, NW = 4, PLW = 32, TW = 32, HW = 4, OW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] now = '0;
  logic op_valid = 1'b0, hnd_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [LW-1:0] op_log = '0;
  logic [NW-1:0] op_num = '0;
  logic [PLW-1:0] op_payload = '0;
  logic [HW-1:0] hnd_data = '0;
  logic op_ready, hnd_ready, rec_valid, rsp_valid;
  logic [HW-1:0] rec_handle;
  logic [TW-1:0] rec_ts, rsp_ovf_first, rsp_ovf_last;
  logic [PLW-1:0] rec_payload;
  logic [1:0] rsp_code, rsp_flags;
  logic [NW-1:0] rsp_count;
  logic [OW-1:0] rsp_ovf_count;
  logic [NL-1:0] log_status, irq;

  always #10 clk = ~clk;
  always @(posedge clk) now <= now + 32'd1;

  evlog_queue #(.NUM_LOGS(NL), .LOG_W(LW), .DEPTH(D), .NUM_W(NW), .PAYLOAD_W(PLW),
                .TS_W(TW), .HANDLE_W(HW), .OVF_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .now(now), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_log(op_log), .op_num(op_num), .op_payload(op_payload),
    .hnd_valid(hnd_valid), .hnd_ready(hnd_ready), .hnd_data(hnd_data),
    .rec_valid(rec_valid), .rec_handle(rec_handle), .rec_ts(rec_ts), .rec_payload(rec_payload),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_flags(rsp_flags), .rsp_count(rsp_count),
    .rsp_ovf_count(rsp_ovf_count), .rsp_ovf_first(rsp_ovf_first), .rsp_ovf_last(rsp_ovf_last),
    .log_status(log_status), .irq(irq));

  typedef struct {logic [HW-1:0] h; logic [TW-1:0] ts; logic [PLW-1:0] p;} rec_t;
  typedef struct {logic [1:0] code; logic [1:0] flags; int cnt; int ovc; logic [TW-1:0] f; logic [TW-1:0] l;} rsp_t;

  rec_t mq[NL][$];
  rec_t erq[$];
  rsp_t esq[$];
  logic [HW-1:0] m_nh[NL];
  int m_ovc[NL];
  logic [TW-1:0] m_f[NL], m_l[NL];
  logic [HW-1:0] hl[8];
  int vectors = 0, miscompares = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  rec_t er;
  rsp_t es;
  always @(negedge clk) if (rst_n) begin
    if (rec_valid) begin
      if (erq.size() == 0) chk("R6", "unexpected record handle", rec_handle, -1);
      else begin
        er = erq.pop_front();
        chk("R2", "record handle", rec_handle, er.h);
        chk("R3", "record timestamp", rec_ts, er.ts);
        chk("R6", "record payload", rec_payload, er.p);
      end
    end
    if (rsp_valid) begin
      if (esq.size() == 0) chk("R12", "unexpected response code", rsp_code, -1);
      else begin
        es = esq.pop_front();
        chk("R8", "response code", rsp_code, es.code);
        chk("R7", "response flags", rsp_flags, es.flags);
        chk("R6", "response count", rsp_count, es.cnt);
        chk("R4", "overflow count", rsp_ovf_count, es.ovc);
        chk("R4", "first overflow time", rsp_ovf_first, es.f);
        chk("R4", "last overflow time", rsp_ovf_last, es.l);
      end
    end
  end

  task automatic wait_idle();
    while (!op_ready) @(negedge clk);
  endtask

  task automatic do_ins(int l, logic [PLW-1:0] p);
    bit exp_irq = 0;
    logic [TW-1:0] t;
    logic [NL-1:0] st_before = log_status;
    @(negedge clk);
    op_valid = 1; op_code = 2'd0; op_log = LW'(l); op_num = '0; op_payload = p; t = now;
    if (l < NL) begin
      if (mq[l].size() == D) begin
        if (m_ovc[l] == 0) m_f[l] = t;
        if (m_ovc[l] < (1 << OW) - 1) m_ovc[l]++;
        m_l[l] = t;
      end else begin
        exp_irq = (mq[l].size() == 0);
        mq[l].push_back('{m_nh[l], t, p});
        m_nh[l] = (m_nh[l] == {HW{1'b1}}) ? HW'(1) : m_nh[l] + HW'(1);
      end
    end
    @(negedge clk);
    op_valid = 0;
    chk("R5", "irq after insert", irq, exp_irq ? (1 << l) : 0);
    if (l < NL) chk("R5", "status after insert", log_status[l], 1);
    else chk("R10", "status after ignored insert", log_status, st_before);
  endtask

  task automatic do_rd(int l, int mx);
    int n;
    @(negedge clk);
    op_valid = 1; op_code = 2'd1; op_log = LW'(l); op_num = NW'(mx);
    if (l >= NL) esq.push_back('{2'd1, 2'd0, 0, 0, '0, '0});
    else begin
      n = (mx < mq[l].size()) ? mx : mq[l].size();
      for (int i = 0; i < n; i++) erq.push_back(mq[l][i]);
      esq.push_back('{2'd0, {mq[l].size() != 0, m_ovc[l] != 0}, n, m_ovc[l],
                      (m_ovc[l] != 0) ? m_f[l] : '0, (m_ovc[l] != 0) ? m_l[l] : '0});
    end
    @(negedge clk);
    op_valid = 0;
    wait_idle();
  endtask

  task automatic do_clr(int l, int n);
    bit err;
    int rm;
    err = (l >= NL);
    if (!err) begin
      rm = (n < mq[l].size()) ? n : mq[l].size();
      for (int i = 0; i < rm; i++)
        if (hl[i] == 0 || hl[i] != mq[l][i].h) err = 1;
    end
    if (err) esq.push_back('{2'd1, 2'd0, 0, 0, '0, '0});
    else begin
      esq.push_back('{2'd0, 2'd0, rm, 0, '0, '0});
      for (int i = 0; i < rm; i++) void'(mq[l].pop_front());
      if (rm > 0) begin m_ovc[l] = 0; m_f[l] = '0; m_l[l] = '0; end
    end
    @(negedge clk);
    op_valid = 1; op_code = 2'd2; op_log = LW'(l); op_num = NW'(n);
    @(negedge clk);
    op_valid = 0;
    for (int i = 0; i < n; i++) begin
      hnd_valid = 1; hnd_data = hl[i];
      @(negedge clk);
    end
    hnd_valid = 0;
    wait_idle();
    if (l < NL) chk("R9", "status after clear", log_status[l], mq[l].size() != 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R12 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_nh[i] = 1; m_ovc[i] = 0; m_f[i] = '0; m_l[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "ready after reset", op_ready, 1);
    chk("R5", "status after reset", log_status, 0);
    chk("R5", "irq after reset", irq, 0);
    chk("R6", "no response after reset", rsp_valid, 0);

    do_rd(0, 8);                               // R6 R7 empty log
    for (int k = 0; k < 3; k++) do_ins(0, 32'hA000 + k);  // R2 handles 1..3, R5 irq once
    do_rd(0, 2);                               // R6 limit below occupancy
    do_rd(0, 8);
    do_ins(1, 32'hB001);                       // R11 own handle counter
    for (int k = 3; k < 8; k++) do_ins(0, 32'hA000 + k);
    for (int k = 0; k < 3; k++) do_ins(0, 32'hDEAD);      // R1 R4 drops
    do_rd(0, 8);                               // R7 overflow flag
    for (int k = 0; k < 6; k++) do_ins(0, 32'hBEEF);      // R4 saturation
    do_rd(0, 0);

    hl[0] = mq[0][0].h; hl[1] = mq[0][1].h + HW'(1);      // R8 mismatch in second slot
    do_clr(0, 2);
    hl[0] = '0;                                // R8 zero handle
    do_clr(0, 1);
    do_rd(0, 1);
    hl[0] = mq[0][0].h; hl[1] = mq[0][1].h;    // R9 good clear resets overflow
    do_clr(0, 2);
    do_rd(0, 8);

    do_ins(5, 32'h5555);                       // R10 invalid log type
    do_rd(5, 4);
    hl[0] = 1; hl[1] = 2;
    do_clr(5, 2);

    hl[0] = mq[1][0].h; hl[1] = 7; hl[2] = 9;  // R8 handles beyond occupancy unchecked
    do_clr(1, 3);
    for (int i = 0; i < 6; i++) hl[i] = mq[0][i].h;
    do_clr(0, 6);                              // R9 log empties

    for (int k = 0; k < 17; k++) begin         // R2 wrap skips zero
      do_ins(2, 32'hC000 + k);
      do_rd(2, 1);
      hl[0] = mq[2][0].h;
      do_clr(2, 1);
    end
    chk("R11", "untouched log status", log_status[3], 0);

    repeat (4) @(negedge clk);
    chk("R6", "pending records", erq.size(), 0);
    chk("R12", "pending responses", esq.size(), 0);
    summary();
    $finish;
  end
endmodule